// File: doc/BRIEF.md
# Buffer Read-Pointer Compare Interrupt

This block watches the read side of a circular elementary-stream buffer and raises an interrupt when one of its read pointers arrives at an address that the host has chosen. The host splits the 19-bit target over three byte-wide write-only registers. It selects which of three read pointers is watched, or turns watching off, through a two-bit mode field.

When the watched pointer becomes equal to the target, the block sets a sticky event bit in a status register. If that event is not masked, the block pulls an active-low interrupt pin. The host responds by reading the status register, which returns the event bit and clears it. It then releases the pin by writing a clear bit in a control register. A typical use is to mark the moment that a chosen piece of buffered data starts to be consumed, which helps align one stream with another.

Top module: `ptr_cmp_irq`

## Requirements
- R1: The target is written at register 0 (target bits [7:0]), register 1 (bits [15:8]) and register 2 (bits [2:0] give target bits [18:16]). Bits [7:3] of register 2 are ignored.
- R2: Only the status register (address 5) returns data on a read. A read at any other address (target 0..2, mode 3, mask 4, control 6) returns 0x00.
- R3: Bits [1:0] of register 3 select the compared pointer. 00 disables comparison, 01 selects rd_ptr_i[0], 10 selects rd_ptr_i[1] and 11 selects rd_ptr_i[2].
- R4: An event occurs when the selected pointer becomes equal to the target, meaning it was not equal (or comparison was off) in the previous cycle. The event sets status bit 6 at the next clock edge.
- R5: A pointer that stays equal to the target does not cause a further event. A new event needs the pointer to leave the target and come back.
- R6: The status bit is sticky. A read of address 5 returns it and clears it at that clock edge. An event in the same cycle as the read wins, so the bit stays set.
- R7: Bit 6 of register 4 set to 1 masks the event. A masked event still sets the status bit, but irq_n_o stays high.
- R8: irq_n_o goes low at the clock edge after an unmasked event that finds the status bit clear. An event that occurs while the status bit is already set does not change the pin.
- R9: Writing register 6 with bit 0 = 1 drives irq_n_o high at the next edge. A write with bit 0 = 0 has no effect. A new pin-setting event in the same cycle wins.
- R10: Reset clears the target, the mode, the mask and the status bit, and drives irq_n_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 3 | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_en_i | input | 1 | Host register read strobe |
| rd_addr_i | input | 3 | Host read address |
| rd_data_o | output | 8 | Read data, combinational |
| rd_ptr_i | input | 3x19 | Buffer read pointers, index 0..2 |
| irq_n_o | output | 1 | Interrupt pin, active low |

## Verification
The hardest situations to create are the collisions, where two things happen in the same clock cycle. One case is a status read that coincides with a new arrival at the target. The other is a pin-clear write that coincides with a new arrival. The bench reaches both by driving the read or write strobe on the same falling edge that moves the pointer onto the target. It then checks at the ports that the set wins.

A second hard case is a pointer parked on the target after the host has serviced the interrupt. The bench holds the pointer there for several cycles, reads back the status and checks the pin. It then moves the pointer away and back, and checks that an event occurs again.

// File: rtl/ptr_cmp_irq_pkg.sv
package ptr_cmp_irq_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned REG_AW   = 3;
  typedef logic [REG_AW-1:0] reg_addr_t;
  // target bytes occupy addresses TGT_BASE .. TGT_BASE+nbytes-1
  localparam reg_addr_t TGT_BASE  = 3'd0;
  localparam reg_addr_t MODE_ADDR = 3'd3;
  localparam reg_addr_t MASK_ADDR = 3'd4;
  localparam reg_addr_t STAT_ADDR = 3'd5;
  localparam reg_addr_t CTRL_ADDR = 3'd6;
  localparam int unsigned EVT_BIT = 6;
  localparam int unsigned CLR_BIT = 0;
endpackage

// File: rtl/ptr_cmp_regs.sv
module ptr_cmp_regs
  import ptr_cmp_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_addr_t         wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] tgt_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              mask_o,
  output logic              clr_pin_o
);
  localparam int unsigned NBYTES = (ADDR_W + DATA_W - 1) / DATA_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int unsigned LO = b * DATA_W;
    localparam int unsigned W  = (ADDR_W - LO > DATA_W) ? DATA_W : ADDR_W - LO;
    logic [W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (wr_en_i && wr_addr_i == reg_addr_t'(TGT_BASE + b)) byte_q <= wr_data_i[W-1:0];
    end
    assign tgt_o[LO +: W] = byte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      mask_o <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == MODE_ADDR) mode_o <= wr_data_i[MODE_W-1:0];
      if (wr_addr_i == MASK_ADDR) mask_o <= wr_data_i[EVT_BIT];
    end
  end

  assign clr_pin_o = wr_en_i && (wr_addr_i == CTRL_ADDR) && wr_data_i[CLR_BIT];
endmodule

// File: rtl/ptr_match.sv
module ptr_match #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned N_PTR  = 3,
  parameter int unsigned MODE_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_PTR-1:0][ADDR_W-1:0]  rd_ptr_i,
  input  logic [MODE_W-1:0]             mode_i,
  input  logic [ADDR_W-1:0]             tgt_i,
  output logic                          hit_o
);
  logic eq, eq_q;

  // mode value p+1 picks pointer p; zero disables
  always_comb begin
    eq = 1'b0;
    for (int p = 0; p < N_PTR; p++) begin
      if (mode_i == MODE_W'(p + 1)) eq = (rd_ptr_i[p] == tgt_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  assign hit_o = eq && !eq_q;
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic mask_i,
  input  logic stat_rd_i,
  input  logic clr_pin_i,
  output logic evt_o,
  output logic irq_n_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        evt_o <= 1'b0;
    else if (hit_i)     evt_o <= 1'b1;
    else if (stat_rd_i) evt_o <= 1'b0;
  end

  // only a hit that newly sets the status may pull the pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           pin_q <= 1'b0;
    else if (hit_i && !evt_o && !mask_i)   pin_q <= 1'b1;
    else if (clr_pin_i)                    pin_q <= 1'b0;
  end

  assign irq_n_o = ~pin_q;
endmodule

// File: rtl/ptr_cmp_irq.sv
module ptr_cmp_irq
  import ptr_cmp_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned N_PTR  = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [REG_AW-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic                         rd_en_i,
  input  logic [REG_AW-1:0]            rd_addr_i,
  output logic [DATA_W-1:0]            rd_data_o,
  input  logic [N_PTR-1:0][ADDR_W-1:0] rd_ptr_i,
  output logic                         irq_n_o
);
  localparam int unsigned MODE_W = $clog2(N_PTR + 1);

  logic [ADDR_W-1:0] tgt;
  logic [MODE_W-1:0] mode;
  logic              mask, clr_pin, hit, evt, stat_rd;

  ptr_cmp_regs #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .tgt_o(tgt), .mode_o(mode), .mask_o(mask), .clr_pin_o(clr_pin)
  );

  ptr_match #(.ADDR_W(ADDR_W), .N_PTR(N_PTR), .MODE_W(MODE_W)) u_match (
    .clk_i, .rst_ni, .rd_ptr_i, .mode_i(mode), .tgt_i(tgt), .hit_o(hit)
  );

  assign stat_rd = rd_en_i && (rd_addr_i == STAT_ADDR);

  irq_ctl u_irq (
    .clk_i, .rst_ni, .hit_i(hit), .mask_i(mask), .stat_rd_i(stat_rd),
    .clr_pin_i(clr_pin), .evt_o(evt), .irq_n_o
  );

  always_comb begin
    rd_data_o = '0;
    if (stat_rd) rd_data_o[EVT_BIT] = evt;
  end
endmodule

// File: rtl/ptr_cmp_irq_chk.sv
module ptr_cmp_irq_chk
  import ptr_cmp_irq_pkg::*;
#(
  parameter int unsigned MODE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hit,
  input logic              evt,
  input logic              mask,
  input logic              clr_pin,
  input logic [MODE_W-1:0] mode,
  input logic              rd_en_i,
  input logic [REG_AW-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_n_o
);
  a_r4_hit_sets_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> evt);

  a_r3_off_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt) |-> $past(mode) != '0);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == STAT_ADDR && !hit) |=> !evt);

  a_r7_mask_holds_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_n_o) |-> !$past(mask));

  a_r8_pin_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_n_o) |-> $past(hit) && !$past(evt));

  a_r9_clear_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pin && !hit) |=> irq_n_o);

  a_r2_write_only_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i != STAT_ADDR) |-> rd_data_o == '0);
endmodule

bind ptr_cmp_irq ptr_cmp_irq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk_i, .rst_ni, .hit, .evt, .mask, .clr_pin, .mode,
  .rd_en_i, .rd_addr_i, .rd_data_o, .irq_n_o
);

// File: tb/tb_ptr_cmp_irq.sv
`timescale 1ns/1ps
module tb_ptr_cmp_irq;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]        wr_addr = '0, rd_addr = '0;
  logic [7:0]        wr_data = '0, rd_data;
  logic [2:0][18:0]  ptr = '0;
  logic              irq_n;
  int                n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  ptr_cmp_irq dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_ptr_i(ptr), .irq_n_o(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_tgt(input logic [18:0] v);
    wr(3'd0, v[7:0]); wr(3'd1, v[15:8]); wr(3'd2, {5'h1F, v[18:16]});
  endtask

  task automatic set_ptr(input int p, input logic [18:0] v);
    @(negedge clk); ptr[p] = v;
    @(negedge clk);
  endtask

  task automatic chk_stat(input string req, input bit exp);
    logic [7:0] d;
    rd(3'd5, d);
    chk(req, d, exp ? 8'h40 : 8'h00);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [18:0] t;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pin", irq_n, 1'b1);
    rst_n = 1'b1;
    chk_stat("R10 status", 1'b0);
    ptr[0] = '0;
    wr(3'd3, 8'h01);           // target 0 after reset: pointer 0 equal -> event
    @(negedge clk);
    chk("R10 target zero", irq_n, 1'b0);
    chk_stat("R10 target zero status", 1'b1);
    wr(3'd6, 8'h01);
    wr(3'd3, 8'h00);
    // R2 write-only reads
    for (int a = 0; a < 8; a++) begin
      if (a != 5) begin
        wr(3'(a == 6 ? 4 : a), 8'hFF);
        rd(3'(a), d);
        chk("R2 readback", d, 8'h00);
      end
    end
    wr(3'd4, 8'h00); wr(3'd3, 8'h00);
    chk("R2 pin idle", irq_n, 1'b1);

    // R1 walking one over every target bit, plus near miss
    for (int i = 0; i < 19; i++) begin
      t = 19'(1) << i;
      wr(3'd3, 8'h00);
      set_tgt(t);
      set_ptr(0, t ^ (19'(1) << ((i + 1) % 19)));
      wr(3'd3, 8'h01);
      chk("R1 near miss pin", irq_n, 1'b1);
      set_ptr(0, t);
      chk("R1 hit pin", irq_n, 1'b0);
      chk_stat("R1 hit status", 1'b1);
      wr(3'd6, 8'h01);
      chk("R9 release", irq_n, 1'b1);
    end

    // R3 mode x pointer sweep
    t = 19'h5A5A5;
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 3; p++) begin
        wr(3'd3, 8'h00);
        set_tgt(t);
        ptr = '0;
        wr(3'd3, 8'(m));
        set_ptr(p, t);
        chk("R3 mode pin", irq_n, (m == p + 1) ? 1'b0 : 1'b1);
        chk_stat("R3 mode status", m == p + 1);
        wr(3'd6, 8'h01);
      end
    end

    // R5 parked pointer
    wr(3'd3, 8'h00); ptr = '0; wr(3'd3, 8'h01);
    set_ptr(0, t);
    chk_stat("R5 first", 1'b1);
    wr(3'd6, 8'h01);
    repeat (5) @(negedge clk);
    chk_stat("R5 parked status", 1'b0);
    chk("R5 parked pin", irq_n, 1'b1);
    set_ptr(0, t + 1);
    set_ptr(0, t);
    chk("R5 return pin", irq_n, 1'b0);
    chk_stat("R5 return status", 1'b1);
    wr(3'd6, 8'h01);

    // R6 sticky, read clears, set wins over read
    set_ptr(0, 0);
    set_ptr(0, t);
    repeat (4) @(negedge clk);
    chk_stat("R6 sticky", 1'b1);
    chk_stat("R6 cleared", 1'b0);
    wr(3'd6, 8'h01);
    set_ptr(0, 0);
    @(negedge clk); rd_en = 1'b1; rd_addr = 3'd5; ptr[0] = t; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
    chk("R6 collide old value", d, 8'h00);
    chk_stat("R6 set wins", 1'b1);
    wr(3'd6, 8'h01);

    // R7 mask
    wr(3'd4, 8'h40);
    set_ptr(0, 0);
    set_ptr(0, t);
    chk("R7 masked pin", irq_n, 1'b1);
    chk_stat("R7 masked status", 1'b1);
    wr(3'd4, 8'hBF);           // bit 6 clear: unmasked
    set_ptr(0, 0);
    set_ptr(0, t);
    chk("R7 unmasked pin", irq_n, 1'b0);

    // R8 event while status set does not re-pull pin
    wr(3'd6, 8'h01);
    set_ptr(0, 0);
    set_ptr(0, t);
    chk("R8 repeat pin", irq_n, 1'b1);
    chk_stat("R8 repeat status", 1'b1);

    // R9 clear bit 0 only; same-cycle event wins
    set_ptr(0, 0);
    set_ptr(0, t);
    wr(3'd6, 8'hFE);
    chk("R9 no clear", irq_n, 1'b0);
    chk_stat("R9 status", 1'b1);
    set_ptr(0, 0);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h01; ptr[0] = t;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 set wins", irq_n, 1'b0);
    wr(3'd6, 8'h01);
    chk("R9 final release", irq_n, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule